// File: doc/BRIEF.md
# Tagged Lookup Pairing Store

This block holds intermediate records between two dependent lookup operations. The first operation of a pair deposits a 46-bit record. The second operation of the pair collects it later. The record therefore never travels through the architectural register file. The number of slots is the floating-point latency rounded up to a power of two, so a fully pipelined loop never has more records outstanding than the store can hold.

Two retrieval disciplines are selectable. In tag mode, an immediate slot number carried by both operations picks the slot, and pairs may finish in any order. In FIFO mode, the tags are ignored and records come back strictly oldest first. Occupancy flags report empty and full. Misuse raises a one-cycle error pulse and leaves the stored data unchanged: writing an occupied slot, or reading a vacant one. A serial port lets a context switch save every slot, one 47-bit word per cycle, and restore it later.

Top module: `pair_store`

## Requirements
- R1: The slot count is the smallest power of two that is at least `FP_LAT`. With the default `FP_LAT`=6 there are 8 slots, so the FIFO reports full after exactly 8 accepted writes.
- R2: After reset `empty`=1, `full`=0, `rd_valid`=0, `wr_err`=0 and `rd_err`=0.
- R3: In tag mode (`tag_mode`=1), a write stores `wr_rec` in slot `wr_tag` and marks that slot occupied. A read of slot `rd_tag` presents the record on `rd_rec` with `rd_valid`=1 one cycle later and frees the slot. Reads may come in any order.
- R4: In FIFO mode (`tag_mode`=0), the tags are ignored and reads return records in the order they were written.
- R5: A write to an occupied slot, or any write to a full FIFO, pulses `wr_err` for one cycle. The write is dropped and the stored record is unchanged.
- R6: A read of a vacant slot, or of an empty FIFO, pulses `rd_err` for one cycle and gives no `rd_valid`.
- R7: A write and a read in the same cycle are each judged on occupancy before that edge. When they target different slots, both complete without error.
- R8: `sv_word` shows {occupied bit, record} of the slot under the context pointer, and each `sv_en` cycle advances the pointer. Tag mode steps through slots 0 upward. FIFO mode starts at the oldest record.
- R9: Each `rs_en` cycle loads `rs_word` into the slot under the context pointer, setting its occupied bit from bit 46, and advances the pointer. In FIFO mode, restoring from pointer 0 makes slot 0 the oldest record.
- R10: `empty` is 1 exactly when no slot is occupied, and `full` is 1 exactly when every slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_mode | input | 1 | 1 = tag-addressed, 0 = FIFO order |
| wr_en | input | 1 | First-lookup deposit |
| wr_tag | input | 3 | Slot for the deposit in tag mode |
| wr_rec | input | 46 | Record to deposit |
| rd_en | input | 1 | Second-lookup collect |
| rd_tag | input | 3 | Slot to collect in tag mode |
| rd_rec | output | 46 | Collected record |
| rd_valid | output | 1 | `rd_rec` holds a record this cycle |
| empty | output | 1 | No slot occupied |
| full | output | 1 | All slots occupied |
| wr_err | output | 1 | Rejected deposit pulse |
| rd_err | output | 1 | Rejected collect pulse |
| sv_en | input | 1 | Advance the save pointer |
| sv_word | output | 47 | Occupied bit and record under the pointer |
| rs_en | input | 1 | Load `rs_word` and advance the pointer |
| rs_word | input | 47 | Word to restore |

## Verification
A deposit and a collect can land on the same clock edge, and this is the overlap the bench exercises. In tag mode it writes one slot while it reads another that is already filled. It then expects both to succeed without error, and a later read must return the new record. In FIFO mode it writes into a full store and expects the rejection to follow the occupancy seen before the edge. The scoreboard compares every returned record against the order in which the bench expects collections to complete.

// File: rtl/pair_store.sv
module pair_store #(
  parameter int FP_LAT = 6,
  parameter int REC_W  = 46,
  localparam int IDX_W = (FP_LAT > 2) ? $clog2(FP_LAT) : 1,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_mode,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_tag,
  input  logic [REC_W-1:0] wr_rec,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_tag,
  output logic [REC_W-1:0] rd_rec,
  output logic             rd_valid,
  output logic             empty,
  output logic             full,
  output logic             wr_err,
  output logic             rd_err,
  input  logic             sv_en,
  output logic [REC_W:0]   sv_word,
  input  logic             rs_en,
  input  logic [REC_W:0]   rs_word
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [IDX_W-1:0] head, tail, cptr;

  wire [IDX_W-1:0] wi = tag_mode ? wr_tag : tail;
  wire [IDX_W-1:0] ri = tag_mode ? rd_tag : head;
  wire [IDX_W-1:0] si = tag_mode ? cptr : IDX_W'(head + cptr);
  wire wr_ok = wr_en && !vld[wi];
  wire rd_ok = rd_en && vld[ri];

  assign sv_word = {vld[si], mem[si]};
  assign empty   = ~|vld;
  assign full    = &vld;

  always_ff @(posedge clk) begin
    if (rs_en) mem[cptr] <= rs_word[REC_W-1:0];
    else if (wr_ok) mem[wi] <= wr_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      head     <= '0;
      tail     <= '0;
      cptr     <= '0;
      rd_rec   <= '0;
      rd_valid <= 1'b0;
      wr_err   <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      wr_err   <= wr_en && vld[wi];
      rd_err   <= rd_en && !vld[ri];
      if (rd_ok) begin
        rd_rec  <= mem[ri];
        vld[ri] <= 1'b0;
        if (!tag_mode) head <= head + 1'b1;
      end
      if (wr_ok) begin
        vld[wi] <= 1'b1;
        if (!tag_mode) tail <= tail + 1'b1;
      end
      if (sv_en) cptr <= cptr + 1'b1;
      if (rs_en) begin
        vld[cptr] <= rs_word[REC_W];
        cptr      <= cptr + 1'b1;
        if (cptr == '0) head <= '0;
        if (rs_word[REC_W]) tail <= cptr + 1'b1;
        else if (cptr == '0) tail <= '0;
      end
    end
  end
endmodule

// File: rtl/pair_store_chk.sv
module pair_store_chk #(parameter int IDX_W = 3) (
  input logic clk,
  input logic rst_n,
  input logic tag_mode,
  input logic wr_en,
  input logic rd_en,
  input logic rs_en,
  input logic rd_valid,
  input logic empty,
  input logic full,
  input logic wr_err,
  input logic rd_err
);
  p_full_write_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !tag_mode && !rs_en) |=> wr_err);
  p_empty_read_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !rs_en) |=> (rd_err && !rd_valid));
  p_valid_or_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rd_err);
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && !tag_mode && !rs_en) |=> !empty);
  p_stay_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en && !rs_en) |=> empty);
endmodule

bind pair_store pair_store_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tag_mode(tag_mode), .wr_en(wr_en), .rd_en(rd_en),
  .rs_en(rs_en), .rd_valid(rd_valid), .empty(empty), .full(full),
  .wr_err(wr_err), .rd_err(rd_err));

// File: tb/pair_store_test.sv
module pair_store_test;
  logic clk = 0, rst_n = 0;
  logic tag_mode = 1, wr_en = 0, rd_en = 0, sv_en = 0, rs_en = 0;
  logic [2:0] wr_tag = 0, rd_tag = 0;
  logic [45:0] wr_rec = 0, rd_rec;
  logic [46:0] sv_word, rs_word = 0;
  logic rd_valid, empty, full, wr_err, rd_err;
  int n_chk = 0, n_bad = 0;
  logic [45:0] exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  pair_store uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) check("R3 unexpected rd_valid", 1, 0);
    else check(req_q.pop_front(), rd_rec, exp_q.pop_front());
  end

  task automatic op(input logic w, input logic [2:0] wt, input logic [45:0] wd,
                    input logic r, input logic [2:0] rt,
                    input logic ew, input logic er, input string req);
    @(negedge clk);
    wr_en = w; wr_tag = wt; wr_rec = wd; rd_en = r; rd_tag = rt;
    if (r && !er) begin exp_q.push_back(expect_rec(rt)); req_q.push_back(req); end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check({req, " wr_err"}, wr_err, ew);
    check({req, " rd_err"}, rd_err, er);
  endtask

  logic [45:0] model [8];
  logic [45:0] fifo_m[$];
  function automatic logic [45:0] expect_rec(input logic [2:0] t);
    if (tag_mode) return model[t];
    return fifo_m.pop_front();
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 empty", empty, 1); check("R2 full", full, 0);
    check("R2 rd_valid", rd_valid, 0); check("R2 errs", {wr_err, rd_err}, 0);

    model[5] = 46'h0A5A_5A5A_5A5; op(1, 5, model[5], 0, 0, 0, 0, "R3 write5");
    check("R10 not empty", empty, 0);
    model[2] = 46'h0B0B_0B0B_0B0; op(1, 2, model[2], 0, 0, 0, 0, "R3 write2");
    op(0, 0, 0, 1, 2, 0, 0, "R3 read2 first");
    op(0, 0, 0, 1, 5, 0, 0, "R3 read5 second");
    model[3] = 46'h0C3C_3C3C_3C3; op(1, 3, model[3], 0, 0, 0, 0, "R3 write3");
    op(1, 3, 46'h1DDD_DDDD_DDD, 0, 0, 1, 0, "R5 overwrite");
    op(0, 0, 0, 1, 3, 0, 0, "R5 record unchanged");
    op(0, 0, 0, 1, 3, 0, 1, "R6 vacant read");
    check("R6 no rd_valid", rd_valid, 0);
    model[6] = 46'h0F6F_6F6F_6F6; op(1, 6, model[6], 0, 0, 0, 0, "R7 prefill6");
    model[1] = 46'h0E1E_1E1E_1E1; op(1, 1, model[1], 1, 6, 0, 0, "R7 same cycle");
    op(0, 0, 0, 1, 1, 0, 0, "R7 later read1");
    check("R10 empty again", empty, 1);

    tag_mode = 0;
    for (int i = 0; i < 8; i++) begin
      logic [45:0] v = 46'h100 + 46'(i * 7);
      fifo_m.push_back(v);
      op(1, 3'(7 - i), v, 0, 0, 0, 0, "R4 fifo write");
      if (i < 7) check("R1 not full yet", full, 0);
    end
    check("R1 full after 8", full, 1);
    op(1, 0, 46'h3FFF, 0, 0, 1, 0, "R5 full write");
    op(1, 0, 46'h3FFE, 1, 4, 1, 0, "R7 full write plus read");
    for (int i = 0; i < 7; i++) op(0, 0, 0, 1, 3'(i), 0, 0, "R4 fifo order");
    check("R10 fifo empty", empty, 1);
    op(0, 0, 0, 1, 0, 0, 1, "R6 fifo empty read");

    tag_mode = 1;
    model[0] = 46'h2222_0000_000; op(1, 0, model[0], 0, 0, 0, 0, "R8 w0");
    model[4] = 46'h2222_4444_444; op(1, 4, model[4], 0, 0, 0, 0, "R8 w4");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sv_en = 0;
      if (i == 0 || i == 4) check("R8 saved slot", sv_word, {1'b1, model[i]});
      else check("R8 saved vacant", sv_word[46], 0);
      sv_en = 1;
    end
    @(negedge clk); sv_en = 0;
    model[7] = 46'h0777_7777_777;
    for (int i = 0; i < 8; i++) begin
      rs_en = 1; rs_word = (i == 7) ? {1'b1, model[7]} : 47'h0;
      @(negedge clk);
    end
    rs_en = 0;
    op(0, 0, 0, 1, 7, 0, 0, "R9 restored slot7");
    op(0, 0, 0, 1, 0, 0, 1, "R9 slot0 cleared");

    tag_mode = 0;
    for (int i = 0; i < 8; i++) begin
      logic [45:0] v = 46'h5000 + 46'(i);
      rs_en = 1; rs_word = (i < 3) ? {1'b1, v} : 47'h0;
      if (i < 3) fifo_m.push_back(v);
      @(negedge clk);
    end
    rs_en = 0;
    for (int i = 0; i < 3; i++) op(0, 0, 0, 1, 0, 0, 0, "R9 fifo restore order");
    check("R9 empty after restored", empty, 1);

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule